// File: doc/BRIEF.md
# Wired-AND Channel Arbitration Transmitter

This block sits between one HDLC framer and a serial channel that several transmitters share through open-drain drivers, so the line carries the logical AND of everything driven onto it. In each bit time of its own time channel the block drives the framer's bit and reads back the resolved line on the collision input. If the block drove a one but reads a zero, another transmitter holds the channel. The block then releases its output and waits for the channel to go idle. After that it either asks the framer to rewind to the start of the frame, or it reports a failure when the framer no longer holds the start of the frame.

The channel counts as idle once a run of consecutive ones has been read back in channel bit times. The required run length adjusts itself. After power-up it is the low threshold (8). A transmitter that has just finished a frame must wait for the high threshold (10). The requirement drops back to the low value as soon as ten consecutive ones have been observed. A station that has just sent therefore yields to stations that are still waiting, which gives every station a fair, deterministic turn. Inter-frame fill on the channel must be all ones.

The framer side is a bit stream. `bit_valid` says the framer has a frame bit pending. `bit_ready` is high in each channel bit time while the block transmits, and a bit is consumed when both are high. The framer holds a bit until it is consumed. `bit_retry` tells the framer to rewind to the first bit of the frame. `bit_fail` and `frame_done` tell it to discard the frame and move on.

Top module: `mmarb_tx`

## Requirements
- R1: After reset the output enable is low, `txd` is 1, `bit_ready`, `bit_retry`, `bit_fail` and `frame_done` are low, and the idle threshold is the low value (8).
- R2: While waiting, the block neither drives nor accepts bits (`txd_oe`=0, `bit_ready`=0). With `bit_valid` high, it starts driving in the channel bit time that follows the one in which the run of consecutive ones on `cdr` reached the current threshold.
- R3: A zero read on `cdr` in a channel bit time while waiting restarts the run of ones from zero.
- R4: `cdr` values in clock cycles where `bit_en` is low have no effect on the run count.
- R5: While transmitting, each channel bit time with `bit_valid` high has `txd_oe`=1, `txd`=`bit_data` and `bit_ready`=1. Outside channel bit times `txd_oe` is 0.
- R6: A collision is a bit time in which the block drives 1 and reads 0 on `cdr`. It releases the output from the next channel bit time on and restarts the idle run from zero.
- R7: On a collision with `start_held` high, `bit_retry` pulses in that bit time. The frame is retried once the run of ones reaches the unchanged threshold.
- R8: On a collision with `start_held` low, `bit_fail` pulses in that bit time instead of `bit_retry`, and no retry follows, even while the channel stays idle.
- R9: When the bit marked `bit_last` is sent without collision, `frame_done` pulses in that bit time and the threshold becomes 10.
- R10: The threshold returns to 8 once ten consecutive ones have been seen while waiting. A run of only nine ones leaves it at 10.
- R11: A channel bit time while transmitting with `bit_valid` low drives nothing and makes no comparison. Transmission continues with the next valid bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One-cycle strobe marking a bit time of the own time channel |
| cdr | input | 1 | Resolved line value read back from the shared channel |
| bit_valid | input | 1 | Framer has a frame bit pending |
| bit_data | input | 1 | Frame bit to transmit |
| bit_last | input | 1 | Current bit is the last bit of the frame |
| start_held | input | 1 | Framer still holds the first bit of the current frame |
| bit_ready | output | 1 | Bit consumed this cycle when `bit_valid` is also high |
| txd | output | 1 | Bit value presented to the open-drain driver |
| txd_oe | output | 1 | Driver enable; low means the output is released |
| bit_retry | output | 1 | Pulse: rewind the frame to its first bit |
| bit_fail | output | 1 | Pulse: frame lost to a collision and cannot be retried |
| frame_done | output | 1 | Pulse: last frame bit sent without collision |

## Verification
The idle detector is swept by placing one zero at each position of an otherwise all-ones channel. The grant must land exactly a full threshold of bit times after that zero, which separates a correct run restart from a counter that only decrements or ignores zeros. Zeros are also driven on `cdr` in every cycle outside a bit time, which exposes a detector that samples without the strobe. Collisions are placed at each early bit of an all-ones frame, once with the frame start held and once without, which separates retry from failure and checks that the threshold does not change. After a successful frame, idle runs of nine and of ten ones are compared: the first must keep the threshold at 10 and the second must restore 8.

// File: rtl/mmarb_pkg.sv
package mmarb_pkg;
  typedef enum logic {
    ARB_WAIT = 1'b0,
    ARB_SEND = 1'b1
  } arb_state_t;
endpackage

// File: rtl/mmarb_idle_mon.sv
// Counts consecutive ones on the read-back line in channel bit times and
// decides when the channel counts as idle, with a self-adjusting threshold.
module mmarb_idle_mon #(
  parameter int IDLE_LO = 8,
  parameter int IDLE_HI = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic cdr_i,
  input  logic count_en,
  input  logic clr_i,
  input  logic raise_i,
  output logic idle_o,
  output logic hi_o
);
  localparam int CNT_W = $clog2(IDLE_HI + 1);
  localparam logic [CNT_W-1:0] LO_C = CNT_W'(IDLE_LO);
  localparam logic [CNT_W-1:0] HI_C = CNT_W'(IDLE_HI);

  logic [CNT_W-1:0] run_q, run_nxt;
  logic             hi_q;
  logic [CNT_W-1:0] thr;
  logic             sample;

  assign sample  = bit_en & count_en;
  assign thr     = hi_q ? HI_C : LO_C;
  assign run_nxt = cdr_i ? ((run_q == HI_C) ? HI_C : run_q + 1'b1) : '0;
  assign idle_o  = sample & (run_nxt >= thr);
  assign hi_o    = hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      hi_q  <= 1'b0;
    end else begin
      if (clr_i) begin
        run_q <= '0;
      end else if (sample) begin
        run_q <= run_nxt;
      end
      if (raise_i) begin
        hi_q <= 1'b1;
      end else if (sample && run_nxt == HI_C) begin
        hi_q <= 1'b0;
      end
    end
  end

  // R3: a zero in a counted bit time restarts the run
  a_r3_zero_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && !cdr_i) |=> (run_q == '0));
  // R4: the run is untouched outside bit times
  a_r4_hold_off_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && !clr_i) |=> $stable(run_q));
  // R10: ten ones in a row bring the threshold back down
  a_r10_drop_after_ten: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && cdr_i && run_q == HI_C - 1'b1 && !raise_i) |=> !hi_q);
  // R9: a finished frame raises the threshold
  a_r9_raise: assert property (@(posedge clk) disable iff (!rst_n)
    raise_i |=> hi_q);
endmodule

// File: rtl/mmarb_fsm.sv
// Wait/send control: grants on idle, compares driven and read-back bits,
// and reports retry, failure or completion to the framer.
module mmarb_fsm
  import mmarb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic cdr_i,
  input  logic bit_valid,
  input  logic bit_data,
  input  logic bit_last,
  input  logic start_held,
  input  logic idle_i,
  output logic count_en,
  output logic clr_o,
  output logic raise_o,
  output logic drive_o,
  output logic ready_o,
  output logic retry_o,
  output logic fail_o,
  output logic done_o
);
  arb_state_t st_q, st_d;
  logic sending, active, clash;

  assign sending = (st_q == ARB_SEND);
  assign active  = sending & bit_en & bit_valid;
  assign clash   = active & bit_data & ~cdr_i;

  assign drive_o  = active;
  assign ready_o  = sending & bit_en;
  assign retry_o  = clash & start_held;
  assign fail_o   = clash & ~start_held;
  assign done_o   = active & bit_last & ~clash;
  assign count_en = ~sending;
  assign clr_o    = clash | done_o;
  assign raise_o  = done_o;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ARB_WAIT: if (idle_i && bit_valid) st_d = ARB_SEND;
      ARB_SEND: if (clash || done_o)     st_d = ARB_WAIT;
      default:  st_d = ARB_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ARB_WAIT;
    else        st_q <= st_d;
  end

  // R6: a lost bit ends the attempt
  a_r6_release_on_clash: assert property (@(posedge clk) disable iff (!rst_n)
    clash |=> (st_q == ARB_WAIT));
  // R7/R8: retry and failure never coincide
  a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(retry_o && fail_o));
  // R9: completion returns to waiting
  a_r9_done_to_wait: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (st_q == ARB_WAIT));
  // R2: a grant needs both an idle channel and a pending bit
  a_r2_grant_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sending) |-> $past(idle_i && bit_valid));
endmodule

// File: rtl/mmarb_tx.sv
module mmarb_tx #(
  parameter int IDLE_LO = 8,
  parameter int IDLE_HI = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic cdr,
  input  logic bit_valid,
  input  logic bit_data,
  input  logic bit_last,
  input  logic start_held,
  output logic bit_ready,
  output logic txd,
  output logic txd_oe,
  output logic bit_retry,
  output logic bit_fail,
  output logic frame_done
);
  logic idle, hi, count_en, clr, raise, drive;

  mmarb_idle_mon #(.IDLE_LO(IDLE_LO), .IDLE_HI(IDLE_HI)) u_mon (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cdr_i(cdr),
    .count_en(count_en), .clr_i(clr), .raise_i(raise),
    .idle_o(idle), .hi_o(hi)
  );

  mmarb_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cdr_i(cdr),
    .bit_valid(bit_valid), .bit_data(bit_data), .bit_last(bit_last),
    .start_held(start_held), .idle_i(idle), .count_en(count_en),
    .clr_o(clr), .raise_o(raise), .drive_o(drive), .ready_o(bit_ready),
    .retry_o(bit_retry), .fail_o(bit_fail), .done_o(frame_done)
  );

  assign txd_oe = drive;
  assign txd    = drive ? bit_data : 1'b1;

  // R5: the driver is enabled only inside channel bit times
  a_r5_oe_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    txd_oe |-> bit_en);
  // R9: the threshold is high right after a completed frame
  a_r9_hi_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> hi);
endmodule

// File: tb/tb_mmarb_tx.sv
module tb_mmarb_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0, cdr = 1'b0, bv = 1'b0, bd = 1'b0, bl = 1'b0, held = 1'b1;
  logic rdy, txd, oe, rty, fl, dn;
  logic s_rdy, s_txd, s_oe, s_rty, s_fl, s_dn;
  int checks = 0, fails = 0;
  int n;

  always #2.5 clk = ~clk;

  mmarb_tx dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cdr(cdr),
    .bit_valid(bv), .bit_data(bd), .bit_last(bl), .start_held(held),
    .bit_ready(rdy), .txd(txd), .txd_oe(oe), .bit_retry(rty),
    .bit_fail(fl), .frame_done(dn)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One channel bit time; cdr is forced to 0 in the gap cycle (R4).
  task automatic bt(input logic c, input logic v, input logic d, input logic l);
    @(negedge clk);
    bit_en = 1'b1; cdr = c; bv = v; bd = d; bl = l;
    #1;
    s_rdy = rdy; s_txd = txd; s_oe = oe; s_rty = rty; s_fl = fl; s_dn = dn;
    @(negedge clk);
    bit_en = 1'b0; cdr = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bit_en = 1'b0; held = 1'b1; bv = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Feeds idle ones with a pending frame starting with 1; returns number of
  // bit times before the first driven bit (that bit is frame bit 0).
  task automatic grant_len(output int len);
    bit early = 1'b0;
    len = -1;
    for (int i = 0; i < 40; i++) begin
      bt(1'b1, 1'b1, 1'b1, 1'b0);
      if (s_oe) begin len = i; break; end
      if (s_rdy || s_rty || s_fl || s_dn) early = 1'b1;
    end
    chk(!early, "R2 no ready/pulse while waiting", early, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    bt(1'b1, 1'b1, 1'b1, 1'b0);
    chk(!s_oe && s_txd && !s_rdy, "R1 reset outputs", {s_oe, s_txd, s_rdy}, 3'b010);
    chk(!s_rty && !s_fl && !s_dn, "R1 reset pulses", {s_rty, s_fl, s_dn}, 0);
    // R1/R2: low threshold after reset (one idle bit already counted)
    grant_len(n);
    chk(n == 7, "R2 grant after 8 ones from reset", n, 7);

    // R3 sweep: p ones, a zero, then exactly 8 more ones before the grant
    for (int p = 0; p < 8; p++) begin
      do_reset();
      for (int k = 0; k < p; k++) bt(1'b1, 1'b1, 1'b1, 1'b0);
      bt(1'b0, 1'b1, 1'b1, 1'b0);
      grant_len(n);
      chk(n == 8, "R3 zero restarts run (R4 gaps drive 0)", n, 8);
    end

    // R5/R9: clean frame 1,0,1,1,0,1 (bit 0 sent at grant)
    do_reset();
    grant_len(n);
    begin
      logic [5:0] pat = 6'b101101;
      for (int i = 1; i < 6; i++) begin
        bt(pat[i], 1'b1, pat[i], i == 5);
        chk(s_oe && s_txd == pat[i] && s_rdy, "R5 drive bit",
            {s_oe, s_txd, s_rdy}, {1'b1, pat[i], 1'b1});
      end
      chk(s_dn, "R9 frame_done on last bit", s_dn, 1);
    end
    // R10: next grant needs 10 ones
    grant_len(n);
    chk(n == 10, "R10 raised threshold after success", n, 10);
    bt(1'b1, 1'b1, 1'b1, 1'b1);
    chk(s_dn, "R9 second frame done", s_dn, 1);
    // nine ones keep threshold at 10
    for (int k = 0; k < 9; k++) bt(1'b1, 1'b0, 1'b0, 1'b0);
    bt(1'b0, 1'b0, 1'b0, 1'b0);
    grant_len(n);
    chk(n == 10, "R10 nine ones keep threshold", n, 10);
    bt(1'b1, 1'b1, 1'b1, 1'b1);
    // ten ones drop threshold to 8
    for (int k = 0; k < 10; k++) bt(1'b1, 1'b0, 1'b0, 1'b0);
    bt(1'b0, 1'b0, 1'b0, 1'b0);
    grant_len(n);
    chk(n == 8, "R10 ten ones restore threshold", n, 8);
    // R11: invalid bit mid-frame drives nothing, no compare
    bt(1'b0, 1'b0, 1'b1, 1'b0);
    chk(!s_oe && !s_rty && !s_fl, "R11 gap bit not driven", {s_oe, s_rty, s_fl}, 0);
    bt(1'b1, 1'b1, 1'b1, 1'b1);
    chk(s_oe && s_dn, "R11 frame continues", {s_oe, s_dn}, 3);

    // R6/R7/R8: collision at bit j of an all-ones frame, held and not held
    for (int h = 0; h < 2; h++) begin
      for (int j = 1; j < 5; j++) begin
        do_reset();
        held = (h == 1);
        grant_len(n);
        for (int k = 1; k < j; k++) bt(1'b1, 1'b1, 1'b1, 1'b0);
        bt(1'b0, 1'b1, 1'b1, 1'b0);
        if (h == 1) begin
          chk(s_rty && !s_fl, "R7 retry pulse on collision", {s_rty, s_fl}, 2);
          grant_len(n);
          chk(n == 8, "R6 R7 released then retried at 8", n, 8);
        end else begin
          chk(!s_rty && s_fl, "R8 fail pulse on collision", {s_rty, s_fl}, 1);
          begin
            bit seen = 1'b0;
            for (int k = 0; k < 12; k++) begin
              bt(1'b1, 1'b0, 1'b1, 1'b0);
              if (s_oe || s_rty) seen = 1'b1;
            end
            chk(!seen, "R8 no retry after failure", seen, 0);
          end
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule